// File: doc/BRIEF.md
# Split-Transaction Request Issuer with Target Lock

This block sits between a local client and a pipelined bus on which every transfer is split into a request and a separate, later response. The client hands over commands (target id, address, data, read/write). The block turns each command into a single-cell request and presents it on a valid/grant port. It keeps issuing further requests without waiting for responses, up to a fixed number in flight.

Every issued request is recorded in an in-order tracker as a pair: the initiator's own source label and a sequence number. Each returning response is matched against the oldest tracker entry. The client receives each response with an error flag. That flag is raised when the target reports an error or when the response breaks ordering.

While any request to one target is still unanswered, the block refuses commands aimed at another target. The pairing is released in the very cycle the last outstanding response is accepted.

Top module: `split_txn_initiator`

## Requirements
- R1: After reset the block is idle: `req_valid`, `out_valid` and `proto_err` are 0, and `cmd_ready` is 1 for any target.
- R2: Once `req_valid` is 1 it stays 1, with `req_target`, `req_addr`, `req_data` and `req_seq` unchanged, until a clock edge where `req_grant` is 1. That edge completes the transfer, and `req_valid` falls afterwards unless a new command was accepted on the same edge.
- R3: With `req_grant` held at 1, commands to the current target are accepted on consecutive cycles. Every transferred request carries `req_src` equal to the `SRC_ID` parameter and `req_last` = 1. `req_seq` counts up by one per transfer from 0 after reset and wraps modulo 2^`SEQ_W`, where `SEQ_W` = clog2(`DEPTH`)+1.
- R4: While at least one request (held or transferred) has no response, `cmd_ready` is 0 for a command whose `cmd_target` differs from the locked target. It is 1 for the locked target when there is room.
- R5: In the cycle where `rsp_valid` delivers the last outstanding response, `cmd_ready` is already 1 for a command to a different target.
- R6: At most `DEPTH` requests are outstanding. This count includes the one held on the request port. With `DEPTH` outstanding, `cmd_ready` is 0.
- R7: A response accepted on a clock edge appears on `out_valid`/`out_data` after the next edge (with `REG_OUT` = 1). `out_err` equals `rsp_err` when the response matches the oldest outstanding entry.
- R8: A response whose `rsp_src`/`rsp_seq` differ from the oldest entry is delivered with `out_err` = 1, sets `proto_err`, and still retires that entry. `proto_err` stays 1 until reset.
- R9: A response arriving with nothing outstanding is delivered with `out_err` = 1 and sets `proto_err`. It retires nothing, so the next matching response is reported without error.
- R10: A synchronous active-low reset clears the request port, the tracker, the target lock and `proto_err`, so a command to any target is accepted right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Client command present |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_target | input | TGT_W | Target id of the command |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | DATA_W | Command write data |
| cmd_write | input | 1 | 1 = write, 0 = read |
| req_valid | output | 1 | Request packet present on the bus |
| req_grant | input | 1 | Bus takes the request on this edge |
| req_target | output | TGT_W | Target id of the request |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_write | output | 1 | Request opcode |
| req_src | output | SRC_W | Source label of this initiator |
| req_seq | output | SEQ_W | Sequence number of the request |
| req_last | output | 1 | Last-cell marker (single-cell packets) |
| rsp_valid | input | 1 | Response packet present (always accepted) |
| rsp_src | input | SRC_W | Source label echoed by the target |
| rsp_seq | input | SEQ_W | Sequence number echoed by the target |
| rsp_data | input | DATA_W | Response data |
| rsp_err | input | 1 | Target-reported error |
| out_valid | output | 1 | Response delivered to the client |
| out_data | output | DATA_W | Delivered response data |
| out_err | output | 1 | Target error or ordering violation |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the block with `DEPTH` = 4, 2-bit target ids, 16-bit address and data, and `SRC_ID` = 5. The small depth lets a handful of commands fill the tracker, so the full stall can be reached. It also makes the 3-bit sequence number wrap within the run. The default registered response path is used, so each delivered response is expected one edge after it is accepted.

// File: rtl/split_txn_pkg.sv
package split_txn_pkg;

   // Classification of one incoming response against the tracker head
   typedef enum logic [1:0] {
      VERD_OK      = 2'd0,
      VERD_TGT_ERR = 2'd1,
      VERD_ORDER   = 2'd2,
      VERD_ORPHAN  = 2'd3
   } rsp_verdict_e;

   function automatic int unsigned count_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/split_txn_fifo.sv
module split_txn_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = split_txn_pkg::count_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("split_txn_fifo: DEPTH must be a power of two of at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("split_txn_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop && (count != '0);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

endmodule

// File: rtl/split_txn_req_stage.sv
module split_txn_req_stage #(
   parameter int TGT_W  = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SEQ_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TGT_W-1:0]  ld_target,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_write,
   input  logic              grant,
   output logic              valid,
   output logic              xfer,
   output logic [TGT_W-1:0]  target,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic              write,
   output logic [SEQ_W-1:0]  seq
);

   assign xfer = valid && grant;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         seq    <= '0;
         target <= '0;
         addr   <= '0;
         data   <= '0;
         write  <= 1'b0;
      end else begin
         if (xfer) seq <= seq + 1'b1;
         if (load) begin
            valid  <= 1'b1;
            target <= ld_target;
            addr   <= ld_addr;
            data   <= ld_data;
            write  <= ld_write;
         end else if (xfer) begin
            valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/split_txn_rsp_check.sv
module split_txn_rsp_check
   import split_txn_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SRC_W   = 4,
   parameter int SEQ_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_valid,
   input  logic [SRC_W-1:0]  rsp_src,
   input  logic [SEQ_W-1:0]  rsp_seq,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_err,
   input  logic              have_entry,
   input  logic [SRC_W-1:0]  head_src,
   input  logic [SEQ_W-1:0]  head_seq,
   output logic              pop,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_err,
   output logic              proto_err
);

   rsp_verdict_e verdict;
   logic         order_bad;
   logic         flag_err;

   always_comb begin
      if (!have_entry)                                  verdict = VERD_ORPHAN;
      else if (rsp_src != head_src || rsp_seq != head_seq) verdict = VERD_ORDER;
      else if (rsp_err)                                 verdict = VERD_TGT_ERR;
      else                                              verdict = VERD_OK;
   end

   assign pop       = rsp_valid && have_entry;
   assign order_bad = rsp_valid && (verdict == VERD_ORDER || verdict == VERD_ORPHAN);
   assign flag_err  = (verdict != VERD_OK);

   always_ff @(posedge clk) begin
      if (!rst_n)         proto_err <= 1'b0;
      else if (order_bad) proto_err <= 1'b1;
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
         end else begin
            out_valid <= rsp_valid;
            out_data  <= rsp_valid ? rsp_data : out_data;
            out_err   <= rsp_valid && flag_err;
         end
      end
   end else begin : g_comb_out
      assign out_valid = rsp_valid;
      assign out_data  = rsp_data;
      assign out_err   = rsp_valid && flag_err;
   end

endmodule

// File: rtl/split_txn_initiator.sv
module split_txn_initiator #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int TGT_W   = 4,
   parameter int SRC_W   = 4,
   parameter int SRC_ID  = 1,
   parameter int DEPTH   = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int SEQ_W  = $clog2(DEPTH) + 1,
   localparam int CW     = split_txn_pkg::count_bits(DEPTH),
   localparam int FW     = SRC_W + SEQ_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [TGT_W-1:0]  cmd_target,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              cmd_write,
   output logic              req_valid,
   input  logic              req_grant,
   output logic [TGT_W-1:0]  req_target,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              req_write,
   output logic [SRC_W-1:0]  req_src,
   output logic [SEQ_W-1:0]  req_seq,
   output logic              req_last,
   input  logic              rsp_valid,
   input  logic [SRC_W-1:0]  rsp_src,
   input  logic [SEQ_W-1:0]  rsp_seq,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_err,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_err,
   output logic              proto_err
);

   if (SRC_ID < 0 || SRC_ID >= (1 << SRC_W)) begin : g_bad_src
      $error("split_txn_initiator: SRC_ID does not fit in SRC_W bits");
   end
   if (TGT_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_widths
      $error("split_txn_initiator: widths must be positive");
   end

   logic             xfer, pop, load;
   logic [CW-1:0]    occ;
   logic [FW-1:0]    head;
   logic [TGT_W-1:0] lock_tgt;
   logic [CW:0]      inflight_after;
   logic             tgt_ok, room;

   assign req_src  = SRC_W'(SRC_ID);
   assign req_last = 1'b1;

   // Requests still owed a response once this edge's pop has happened
   assign inflight_after = {1'b0, occ} - (CW+1)'(pop) + (CW+1)'(req_valid);
   assign tgt_ok    = (inflight_after == '0) || (cmd_target == lock_tgt);
   assign room      = inflight_after < (CW+1)'(DEPTH);
   assign cmd_ready = (!req_valid || xfer) && tgt_ok && room;
   assign load      = cmd_valid && cmd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)    lock_tgt <= '0;
      else if (load) lock_tgt <= cmd_target;
   end

   split_txn_req_stage #(
      .TGT_W (TGT_W),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .SEQ_W (SEQ_W)
   ) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .ld_target(cmd_target),
      .ld_addr  (cmd_addr),
      .ld_data  (cmd_data),
      .ld_write (cmd_write),
      .grant    (req_grant),
      .valid    (req_valid),
      .xfer     (xfer),
      .target   (req_target),
      .addr     (req_addr),
      .data     (req_data),
      .write    (req_write),
      .seq      (req_seq)
   );

   split_txn_fifo #(
      .WIDTH(FW),
      .DEPTH(DEPTH)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (xfer),
      .push_data({req_src, req_seq}),
      .pop      (pop),
      .head     (head),
      .count    (occ)
   );

   split_txn_rsp_check #(
      .DATA_W (DATA_W),
      .SRC_W  (SRC_W),
      .SEQ_W  (SEQ_W),
      .REG_OUT(REG_OUT)
   ) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rsp_valid (rsp_valid),
      .rsp_src   (rsp_src),
      .rsp_seq   (rsp_seq),
      .rsp_data  (rsp_data),
      .rsp_err   (rsp_err),
      .have_entry(occ != '0),
      .head_src  (head[FW-1:SEQ_W]),
      .head_seq  (head[SEQ_W-1:0]),
      .pop       (pop),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_err   (out_err),
      .proto_err (proto_err)
   );

endmodule

// File: rtl/split_txn_chk.sv
module split_txn_chk #(
   parameter int TGT_W  = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SEQ_W  = 4,
   parameter int CW     = 4,
   parameter int DEPTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [TGT_W-1:0]  cmd_target,
   input logic              req_valid,
   input logic              req_grant,
   input logic [TGT_W-1:0]  req_target,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_data,
   input logic [SEQ_W-1:0]  req_seq,
   input logic              proto_err,
   input logic [CW-1:0]     occ,
   input logic [TGT_W-1:0]  lock_tgt
);

   assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_grant |=> req_valid && $stable(req_addr) && $stable(req_data)
                                  && $stable(req_target) && $stable(req_seq))
      else $error("R2: request changed or dropped before grant");

   assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_grant |=> !req_valid || req_seq == SEQ_W'($past(req_seq) + 1'b1))
      else $error("R3: sequence number did not advance by one");

   assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && occ > CW'(1) |-> cmd_target == lock_tgt)
      else $error("R4: command to another target accepted while responses pending");

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH))
      else $error("R6: outstanding count above depth");

   assert_sticky_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err)
      else $error("R8: protocol error flag cleared without reset");

   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= !rst_n;

   always @(negedge clk) begin
      if (rst_seen === 1'b1) begin
         assert_reset_clear_R10: assert (!req_valid && !proto_err && occ == '0)
            else $error("R10: state not cleared by reset");
      end
   end

endmodule

bind split_txn_initiator split_txn_chk #(
   .TGT_W (TGT_W),
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .SEQ_W (SEQ_W),
   .CW    (CW),
   .DEPTH (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_target(cmd_target),
   .req_valid (req_valid),
   .req_grant (req_grant),
   .req_target(req_target),
   .req_addr  (req_addr),
   .req_data  (req_data),
   .req_seq   (req_seq),
   .proto_err (proto_err),
   .occ       (occ),
   .lock_tgt  (lock_tgt)
);

// File: tb/split_txn_initiator_tb.sv
`timescale 1ns/1ps
module split_txn_initiator_tb;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 16;
   localparam int TGT_W  = 2;
   localparam int SRC_W  = 4;
   localparam int SRC_ID = 5;
   localparam int DEPTH  = 4;
   localparam int SEQ_W  = $clog2(DEPTH) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [TGT_W-1:0]  cmd_target = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [DATA_W-1:0] cmd_data = '0;
   logic              cmd_write = 1'b0;
   logic              req_valid;
   logic              req_grant = 1'b0;
   logic [TGT_W-1:0]  req_target;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_data;
   logic              req_write;
   logic [SRC_W-1:0]  req_src;
   logic [SEQ_W-1:0]  req_seq;
   logic              req_last;
   logic              rsp_valid = 1'b0;
   logic [SRC_W-1:0]  rsp_src = '0;
   logic [SEQ_W-1:0]  rsp_seq = '0;
   logic [DATA_W-1:0] rsp_data = '0;
   logic              rsp_err = 1'b0;
   logic              out_valid;
   logic [DATA_W-1:0] out_data;
   logic              out_err;
   logic              proto_err;

   always #2 clk = ~clk;

   split_txn_initiator #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TGT_W(TGT_W), .SRC_W(SRC_W),
      .SRC_ID(SRC_ID), .DEPTH(DEPTH), .REG_OUT(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_target(cmd_target),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_write(cmd_write),
      .req_valid(req_valid), .req_grant(req_grant), .req_target(req_target),
      .req_addr(req_addr), .req_data(req_data), .req_write(req_write),
      .req_src(req_src), .req_seq(req_seq), .req_last(req_last),
      .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_seq(rsp_seq),
      .rsp_data(rsp_data), .rsp_err(rsp_err),
      .out_valid(out_valid), .out_data(out_data), .out_err(out_err),
      .proto_err(proto_err)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Scoreboard: expected client deliveries and sequence numbers seen at the target
   logic [DATA_W-1:0] exp_data[$];
   logic              exp_err[$];
   logic [SEQ_W-1:0]  tgt_seq_q[$];
   int                exp_seq = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Target-side monitor: records every request transfer (R3)
   always begin
      @(negedge clk); #1;
      if (rst_n && req_valid && req_grant) begin
         check(req_seq == SEQ_W'(exp_seq), "R3", "req_seq", int'(req_seq), exp_seq % (1 << SEQ_W));
         check(req_src == SRC_W'(SRC_ID) && req_last, "R3", "req_src/last",
               int'(req_src), SRC_ID);
         tgt_seq_q.push_back(req_seq);
         exp_seq = (exp_seq + 1) % (1 << SEQ_W);
      end
   end

   // Client-side monitor: compares deliveries with the scoreboard (R7)
   always begin
      @(negedge clk); #1;
      if (rst_n && out_valid) begin
         if (exp_data.size() == 0) begin
            check(1'b0, "R7", "unexpected delivery", int'(out_data), -1);
         end else begin
            logic [DATA_W-1:0] d;
            logic              e;
            d = exp_data.pop_front();
            e = exp_err.pop_front();
            check(out_data == d, "R7", "out_data", int'(out_data), int'(d));
            check(out_err == e, "R7", "out_err", int'(out_err), int'(e));
         end
      end
   end

   task automatic send_cmd(input int tgt, input int addr, input int data, output int waits);
      @(negedge clk);
      cmd_valid  = 1'b1;
      cmd_target = TGT_W'(tgt);
      cmd_addr   = ADDR_W'(addr);
      cmd_data   = DATA_W'(data);
      cmd_write  = 1'b1;
      waits = 0;
      #0.5;
      while (!cmd_ready && waits < 50) begin
         @(negedge clk); #0.5;
         waits++;
      end
      @(posedge clk);
   endtask

   task automatic cmd_idle();
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // Respond to the oldest transferred request; corrupt flips the sequence number
   task automatic respond(input bit corrupt, input int data, input bit err,
                          input int exp_ready, input string req);
      logic [SEQ_W-1:0] s;
      s = tgt_seq_q.pop_front();
      @(negedge clk);
      rsp_valid = 1'b1;
      rsp_src   = SRC_W'(SRC_ID);
      rsp_seq   = corrupt ? (s ^ SEQ_W'(1)) : s;
      rsp_data  = DATA_W'(data);
      rsp_err   = err;
      exp_data.push_back(DATA_W'(data));
      exp_err.push_back(err | corrupt);
      #0.5;
      if (exp_ready >= 0)
         check(cmd_ready == exp_ready[0], req, "cmd_ready during response",
               int'(cmd_ready), exp_ready);
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      rsp_valid = 1'b0;
      req_grant = 1'b0;
      repeat (2) @(negedge clk);
      exp_data.delete();
      exp_err.delete();
      tgt_seq_q.delete();
      exp_seq = 0;
      rst_n = 1'b1;
   endtask

   initial begin
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: idle state after reset
      check(!req_valid && !out_valid && !proto_err, "R1", "outputs idle",
            int'({req_valid, out_valid, proto_err}), 0);
      check(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);

      // R2: request held without grant
      send_cmd(1, 16'h1234, 16'hA5A5, w);
      cmd_idle();
      for (int i = 0; i < 3; i++) begin
         #1;
         check(req_valid && req_addr == 16'h1234 && req_data == 16'hA5A5 && req_target == 2'd1,
               "R2", "held request", int'(req_addr), 16'h1234);
         @(negedge clk);
      end
      req_grant = 1'b1;
      @(negedge clk); #1;
      check(!req_valid, "R2", "req_valid after grant", int'(req_valid), 0);

      // R3: back-to-back issue with grant held
      for (int i = 0; i < 3; i++) begin
         send_cmd(1, 16'h2000 + i, 16'h0100 + i, w);
         check(w == 0, "R3", "back-to-back wait cycles", w, 0);
      end
      cmd_idle();

      // R6: tracker full (four outstanding)
      @(negedge clk);
      cmd_valid = 1'b1; cmd_target = 2'd1;
      for (int i = 0; i < 3; i++) begin
         #0.5;
         check(!cmd_ready, "R6", "cmd_ready when full", int'(cmd_ready), 0);
         @(negedge clk);
      end
      cmd_valid = 1'b0;

      // R7: in-order responses, second with target error
      respond(1'b0, 16'h0011, 1'b0, -1, "R7");
      respond(1'b0, 16'h0022, 1'b1, -1, "R7");

      // R4: two outstanding to target 1
      @(negedge clk);
      cmd_target = 2'd2; #0.5;
      check(!cmd_ready, "R4", "ready for other target", int'(cmd_ready), 0);
      cmd_target = 2'd1; #0.5;
      check(cmd_ready, "R4", "ready for locked target", int'(cmd_ready), 1);

      // R5: switch released on the final response
      @(negedge clk);
      cmd_valid = 1'b1; cmd_target = 2'd2; cmd_addr = 16'h3000; cmd_data = 16'h0333;
      respond(1'b0, 16'h0033, 1'b0, 0, "R4");
      respond(1'b0, 16'h0044, 1'b0, 1, "R5");
      cmd_valid = 1'b0;
      repeat (2) @(negedge clk);
      respond(1'b0, 16'h0055, 1'b0, -1, "R7");

      // R8: out-of-order response retires its entry
      send_cmd(2, 16'h4000, 16'h0400, w);
      send_cmd(2, 16'h4001, 16'h0401, w);
      cmd_idle();
      repeat (2) @(negedge clk);
      respond(1'b1, 16'h0066, 1'b0, -1, "R8");
      #1;
      check(proto_err, "R8", "proto_err set", int'(proto_err), 1);
      respond(1'b0, 16'h0077, 1'b0, -1, "R8");
      #1;
      check(proto_err, "R8", "proto_err sticky", int'(proto_err), 1);
      check(exp_data.size() == 0, "R8", "deliveries pending", exp_data.size(), 0);

      // R3: sequence wrap (seq 7 then 0 after this)
      send_cmd(2, 16'h5000, 16'h0500, w);
      cmd_idle();
      repeat (2) @(negedge clk);
      respond(1'b0, 16'h0088, 1'b0, -1, "R3");

      // R10: reset with a request outstanding to target 3
      send_cmd(3, 16'h6000, 16'h0600, w);
      cmd_idle();
      repeat (2) @(negedge clk);
      do_reset();
      #1;
      check(!proto_err && !req_valid, "R10", "cleared by reset",
            int'({proto_err, req_valid}), 0);
      cmd_target = 2'd0; #0.5;
      check(cmd_ready, "R10", "other target ready after reset", int'(cmd_ready), 1);
      req_grant = 1'b1;
      send_cmd(0, 16'h7000, 16'h0700, w);
      cmd_idle();
      repeat (2) @(negedge clk);
      respond(1'b0, 16'h0099, 1'b0, -1, "R10");

      // R9: orphan response with nothing outstanding
      @(negedge clk);
      rsp_valid = 1'b1; rsp_src = SRC_W'(SRC_ID); rsp_seq = '0;
      rsp_data = 16'h00AA; rsp_err = 1'b0;
      exp_data.push_back(16'h00AA); exp_err.push_back(1'b1);
      @(negedge clk);
      rsp_valid = 1'b0; #1;
      check(proto_err, "R9", "proto_err on orphan", int'(proto_err), 1);
      send_cmd(0, 16'h7001, 16'h0701, w);
      cmd_idle();
      repeat (2) @(negedge clk);
      respond(1'b0, 16'h00BB, 1'b0, -1, "R9");
      repeat (3) @(negedge clk);
      check(exp_data.size() == 0, "R9", "deliveries pending", exp_data.size(), 0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule